// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is a slave on a two-wire serial bus. It runs on a fast system clock, oversamples the bus clock and data lines, and pulls the data line low through an open-drain enable. It holds a 256-byte array that a bus master reaches through a fixed sequence. The master first sends a control byte that selects this device and sets the direction. It then sends a command byte that opens memory access, followed by a word address that loads the internal pointer.

On a write, the data bytes that follow are gathered in a small page buffer. A STOP then starts a timed programming cycle, and the buffered bytes land in the array when that cycle ends. While it runs, the device answers nothing. On a read, the master first sets the pointer with a write sequence. It then issues a repeated START and a control byte with the read bit set, and the device streams bytes for as long as the master acknowledges.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged only when bits 7:4 equal 1001 and bits 3:1 equal `dev_sel`. Bit 0 selects the direction: 1 is a read and 0 is a write.
- R2: A control byte that does not match is not acknowledged, and no further byte is acknowledged until the next START.
- R3: An acknowledge holds SDA low for the whole high phase of the ninth clock. The block changes its SDA drive only while SCL is low, or on a START or STOP.
- R4: In a write sequence, the command byte equal to `CMD_ACCESS` (default A5h), the word address and every data byte are each acknowledged. The word address loads the pointer.
- R5: After each received data byte, only the low three pointer bits advance, with page size 8. When more than eight bytes arrive, the page wraps and later bytes overwrite earlier ones at the same slots.
- R6: A STOP after at least one data byte starts a programming cycle of `PROG_CYCLES` clocks. At the end of that cycle every buffered byte is written to its address inside the page, whether one byte was sent or many.
- R7: A repeated START that arrives in place of STOP discards the buffered bytes. No programming cycle starts and the array is left unchanged.
- R8: While a programming cycle runs, no byte is acknowledged, including a matching control byte.
- R9: In a read, bytes are sent MSB first, starting at the pointer. The pointer advances by one per byte over its full 8 bits, so it wraps from FFh to 00h.
- R10: When the master does not acknowledge a read byte, the block releases SDA and drives it no more until the next START.
- R11: A command byte other than `CMD_ACCESS` is acknowledged. The following bytes are not acknowledged until STOP or START, and the pointer is left unchanged.
- R12: After reset, SDA is released and every array location reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_sel | input | 3 | Device select bits compared with control byte bits 3:1 |
| sda_oe | output | 1 | When 1, pull SDA low |

## Verification
Some properties hold on every clock. The data drive never changes while SCL is high, except at START or STOP. The drive stays off for the whole programming cycle. The upper pointer bits stay frozen while a page is being collected. A commit never overlaps a cycle that is already running. Other behaviour only shows through the bench's bus scenarios: selection by address, page wrap with overwrite, abort on repeated START, the busy lockout seen as a missing acknowledge, the pointer wrapping from FFh to 00h on reads, and a foreign command that leaves the pointer unchanged.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CMD,
      ST_WADDR,
      ST_WDATA,
      ST_RDATA,
      ST_SKIP
   } twi_state_e;

   localparam logic [3:0] DEV_NIBBLE = 4'b1001;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_q, sda_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_i;
               sda_pipe[g] <= sda_i;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_pipe[g-1];
               sda_pipe[g] <= sda_pipe[g-1];
            end
      end
   end

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int PROG_CYCLES = 1000000
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            buf_clr,
   input  logic                            buf_we,
   input  logic [$clog2(PAGE_BYTES)-1:0]   buf_idx,
   input  logic [7:0]                      buf_wdata,
   input  logic                            commit,
   input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_base,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [7:0]                      rd_data,
   output logic                            busy,
   output logic                            has_data
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int IDX_W  = $clog2(PAGE_BYTES);
   localparam int BASE_W = ADDR_W - IDX_W;
   localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 1");
   end

   logic [7:0]            mem  [DEPTH];
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid;
   logic [CNT_W-1:0]      timer;
   logic [BASE_W-1:0]     base;

   assign busy     = (timer != '0);
   assign has_data = |valid;
   assign rd_data  = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
         for (int p = 0; p < PAGE_BYTES; p++) pbuf[p] <= 8'h00;
         valid <= '0;
         timer <= '0;
         base  <= '0;
      end else begin
         if (buf_clr && !busy) valid <= '0;
         else if (buf_we) begin
            pbuf[buf_idx]  <= buf_wdata;
            valid[buf_idx] <= 1'b1;
         end
         if (commit) begin
            timer <= CNT_W'(PROG_CYCLES);
            base  <= commit_base;
         end else if (busy) begin
            timer <= timer - CNT_W'(1);
            if (timer == CNT_W'(1)) begin
               for (int i = 0; i < PAGE_BYTES; i++)
                  if (valid[i]) mem[{base, IDX_W'(i)}] <= pbuf[i];
               valid <= '0;
            end
         end
      end

   // R6: a new commit never lands on a running programming cycle
   assert_commit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !busy);
   // R6: the page buffer is empty once the programming cycle ends
   assert_buffer_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !has_data);
   // R8: nothing is collected while the array is being programmed
   assert_no_fill_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> !busy);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter logic [7:0] CMD_ACCESS  = 8'hA5,
   parameter int         PROG_CYCLES = 1000000,
   parameter int         SYNC_STAGES = 2,
   parameter int         PAGE_BYTES  = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] dev_sel,
   output logic       sda_oe
);
   import twi_pkg::*;

   localparam int ADDR_W = 8;
   localparam int IDX_W  = $clog2(PAGE_BYTES);
   localparam int BASE_W = ADDR_W - IDX_W;

   if (PAGE_BYTES < 2 || PAGE_BYTES > 128 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and 128");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, has_data, buf_we, buf_clr, commit;
   logic [7:0] rd_data;

   twi_state_e st, pend;
   logic [3:0] bitcnt;
   logic       in_ack, mack, oe;
   logic [7:0] shreg, txreg, ptr;
   logic       ctrl_hit, byte_done;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign byte_done = scl_fall && !in_ack && (bitcnt == 4'd8);
   assign ctrl_hit  = (shreg[7:4] == DEV_NIBBLE) && (shreg[3:1] == dev_sel) && !busy;
   assign buf_clr   = start_det;
   assign buf_we    = byte_done && (st == ST_WDATA);
   assign commit    = stop_det && (st == ST_WDATA) && has_data && !busy;

   twi_page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(ptr[IDX_W-1:0]), .buf_wdata(shreg),
      .commit(commit), .commit_base(ptr[ADDR_W-1:IDX_W]),
      .rd_addr(ptr), .rd_data(rd_data), .busy(busy), .has_data(has_data)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st     <= ST_IDLE;
         pend   <= ST_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         mack   <= 1'b0;
         oe     <= 1'b0;
         shreg  <= '0;
         txreg  <= '0;
         ptr    <= '0;
      end else if (start_det) begin
         st     <= ST_CTRL;
         bitcnt <= '0;
         in_ack <= 1'b0;
         oe     <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         bitcnt <= '0;
         in_ack <= 1'b0;
         oe     <= 1'b0;
      end else begin
         case (st)
            ST_CTRL, ST_CMD, ST_WADDR, ST_WDATA: begin
               if (scl_rise && !in_ack) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               if (scl_fall && in_ack) begin
                  in_ack <= 1'b0;
                  bitcnt <= '0;
                  oe     <= 1'b0;
                  st     <= pend;
                  if (pend == ST_RDATA) begin
                     txreg <= rd_data;
                     oe    <= ~rd_data[7];
                     ptr   <= ptr + 8'd1;
                  end
               end else if (byte_done) begin
                  in_ack <= 1'b1;
                  oe     <= 1'b1;
                  case (st)
                     ST_CTRL: begin
                        pend <= shreg[0] ? ST_RDATA : ST_CMD;
                        if (!ctrl_hit) begin
                           st     <= ST_SKIP;
                           in_ack <= 1'b0;
                           oe     <= 1'b0;
                        end
                     end
                     ST_CMD:   pend <= (shreg == CMD_ACCESS) ? ST_WADDR : ST_SKIP;
                     ST_WADDR: begin
                        ptr  <= shreg;
                        pend <= ST_WDATA;
                     end
                     default: begin
                        ptr[IDX_W-1:0] <= ptr[IDX_W-1:0] + IDX_W'(1);
                        pend <= ST_WDATA;
                     end
                  endcase
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  if (in_ack) mack <= ~sda_s;
                  else        bitcnt <= bitcnt + 4'd1;
               end
               if (scl_fall) begin
                  if (in_ack) begin
                     in_ack <= 1'b0;
                     bitcnt <= '0;
                     if (mack) begin
                        txreg <= rd_data;
                        oe    <= ~rd_data[7];
                        ptr   <= ptr + 8'd1;
                     end else begin
                        st <= ST_SKIP;
                        oe <= 1'b0;
                     end
                  end else if (bitcnt == 4'd8) begin
                     oe     <= 1'b0;
                     in_ack <= 1'b1;
                  end else begin
                     txreg <= {txreg[6:0], 1'b0};
                     oe    <= ~txreg[6];
                  end
               end
            end
            default: ;
         endcase
      end

   assign sda_oe = oe;

   // R8: the line is never pulled during a programming cycle
   assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !oe);
   // R3: drive changes only with SCL low or at a bus condition
   assert_drive_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe != $past(oe)) |-> (!scl_s || $past(start_det) || $past(stop_det)));
   // R5: page slot advances without touching the page base
   assert_page_base_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WDATA && $past(st) == ST_WDATA) |-> (ptr[ADDR_W-1:IDX_W] == $past(ptr[ADDR_W-1:IDX_W])));
endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
   localparam int         Q     = 8;
   localparam int         PROG  = 400;
   localparam logic [2:0] DEV   = 3'b101;
   localparam logic [7:0] CMD   = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] model [256];
   logic [7:0] wq [$];

   always #5 clk = ~clk;

   twi_eeprom_slave #(.CMD_ACCESS(CMD), .PROG_CYCLES(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .dev_sel(DEV), .sda_oe(sda_oe)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic q_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; q_wait(Q);
      scl_m = 1'b1; q_wait(Q);
      sda_m = 1'b0; q_wait(Q);
      scl_m = 1'b0; q_wait(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q_wait(Q);
      scl_m = 1'b1; q_wait(Q);
      sda_m = 1'b1; q_wait(Q);
   endtask

   // returns 1 when the slave held SDA low through the whole ninth high phase
   task automatic send_byte(input logic [7:0] b, output bit ackd);
      bit a1, a2;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q_wait(Q);
         scl_m = 1'b1; q_wait(2 * Q);
         scl_m = 1'b0; q_wait(Q);
      end
      sda_m = 1'b1; q_wait(Q);
      scl_m = 1'b1; q_wait(1);
      a1 = ~sda_line; q_wait(2 * Q - 2);
      a2 = ~sda_line; q_wait(1);
      scl_m = 1'b0; q_wait(Q);
      if (a1 != a2) chk(1'b0, "R3 ack not steady over high phase", a1, a2);
      ackd = a1 & a2;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q_wait(Q);
         scl_m = 1'b1; q_wait(Q);
         b[i] = sda_line; q_wait(Q);
         scl_m = 1'b0;
      end
      q_wait(Q);
      sda_m = give_ack ? 1'b0 : 1'b1; q_wait(Q);
      scl_m = 1'b1; q_wait(2 * Q);
      scl_m = 1'b0; q_wait(Q);
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] ctrl(input logic [2:0] sel, input bit rd);
      return {4'b1001, sel, rd};
   endfunction

   task automatic send_exp(input logic [7:0] b, input bit exp, input string tag);
      bit a;
      send_byte(b, a);
      chk(a == exp, tag, a, exp);
   endtask

   // write the bytes in wq starting at addr, then let programming finish
   task automatic page_write(input logic [7:0] addr);
      bus_start();
      send_exp(ctrl(DEV, 1'b0), 1'b1, "R1 control write ack");
      send_exp(CMD, 1'b1, "R4 access command ack");
      send_exp(addr, 1'b1, "R4 word address ack");
      foreach (wq[i]) send_exp(wq[i], 1'b1, "R4 data byte ack");
      bus_stop();
      foreach (wq[i]) model[{addr[7:3], 3'(addr[2:0] + 3'(i))}] = wq[i];
      q_wait(PROG + 20);
   endtask

   task automatic set_ptr(input logic [7:0] addr);
      send_exp(ctrl(DEV, 1'b0), 1'b1, "R1 control write ack");
      send_exp(CMD, 1'b1, "R4 access command ack");
      send_exp(addr, 1'b1, "R4 word address ack");
   endtask

   task automatic check_release();
      bit hi;
      sda_m = 1'b1; q_wait(Q);
      scl_m = 1'b1; q_wait(Q);
      hi = sda_line; q_wait(Q);
      scl_m = 1'b0; q_wait(Q);
      chk(hi == 1'b1 && sda_oe == 1'b0, "R10 SDA released after master nack", hi, 1);
   endtask

   task automatic read_seq(input logic [7:0] addr, input int n, input string tag);
      logic [7:0] b;
      bus_start();
      set_ptr(addr);
      bus_start();
      send_exp(ctrl(DEV, 1'b1), 1'b1, "R1 control read ack");
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, b);
         chk(b === model[8'(addr + 8'(i))], tag, b, model[8'(addr + 8'(i))]);
      end
      check_release();
      bus_stop();
   endtask

   initial begin
      logic [7:0] b;
      for (int a = 0; a < 256; a++) model[a] = 8'hFF;
      q_wait(5);
      chk(sda_oe == 1'b0, "R12 SDA released in reset", sda_oe, 0);
      rst_n = 1'b1;
      q_wait(5);
      chk(sda_oe == 1'b0, "R12 SDA released after reset", sda_oe, 0);
      read_seq(8'h00, 2, "R12 erased array reads FF");

      // page mode then byte mode
      wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
      page_write(8'h10);
      read_seq(8'h10, 3, "R6 page mode commit / R9 read stream");

      // byte mode with busy lockout probed right after STOP
      bus_start();
      set_ptr(8'h20);
      send_exp(8'h9C, 1'b1, "R4 data byte ack");
      bus_stop();
      model[8'h20] = 8'h9C;
      bus_start();
      send_exp(ctrl(DEV, 1'b0), 1'b0, "R8 no ack while programming");
      bus_stop();
      q_wait(PROG + 20);
      read_seq(8'h1F, 3, "R6 byte mode commit");

      // page wrap with overwrite
      wq.delete();
      for (int i = 0; i < 10; i++) wq.push_back(8'(8'hD0 + i));
      page_write(8'h35);
      read_seq(8'h30, 8, "R5 page wrap overwrite");
      read_seq(8'h38, 1, "R5 next page untouched");

      // repeated START in place of STOP aborts
      bus_start();
      set_ptr(8'h50);
      send_exp(8'h12, 1'b1, "R4 data byte ack");
      send_exp(8'h34, 1'b1, "R4 data byte ack");
      bus_start();
      send_exp(ctrl(DEV, 1'b0), 1'b1, "R7 device free after abort");
      bus_stop();
      q_wait(PROG + 20);
      read_seq(8'h50, 2, "R7 aborted write left array unchanged");

      // selection mismatches
      bus_start();
      send_exp(ctrl(3'b100, 1'b0), 1'b0, "R2 wrong select bits not acked");
      send_exp(CMD, 1'b0, "R2 following byte ignored");
      bus_stop();
      bus_start();
      send_exp({4'b1010, DEV, 1'b0}, 1'b0, "R2 wrong type nibble not acked");
      bus_stop();

      // foreign command keeps pointer
      bus_start();
      set_ptr(8'h11);
      bus_stop();
      bus_start();
      send_exp(ctrl(DEV, 1'b0), 1'b1, "R1 control write ack");
      send_exp(8'h33, 1'b1, "R11 foreign command acked");
      send_exp(8'h70, 1'b0, "R11 byte after foreign command ignored");
      bus_stop();
      bus_start();
      send_exp(ctrl(DEV, 1'b1), 1'b1, "R1 control read ack");
      recv_byte(1'b0, b);
      chk(b === model[8'h11], "R11 pointer unchanged by foreign command", b, model[8'h11]);
      check_release();
      bus_stop();

      // pointer wrap FFh -> 00h on reads
      wq.delete(); wq.push_back(8'h5A);
      page_write(8'hFF);
      wq.delete(); wq.push_back(8'hC3);
      page_write(8'h00);
      read_seq(8'hFF, 2, "R9 pointer wraps FF to 00");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule